// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps a bank of wide event counters for an Ethernet MAC. Each receive or transmit datapath event arrives as a one-cycle pulse on its own bit of an event vector. Most counters add one per pulse. Two counters are octet counters: one for good received bytes and one for good transmitted bytes. Each adds a byte count supplied with its pulse at end of frame. The counters never stop, and no event is lost while the host reads them.

The host works through a small register port. Writing the command register can take a snapshot, clear the bank, or do both. A snapshot copies every live counter into a read-side shadow on the same clock edge, so the host reads one consistent set, 16 bits at a time. Each counter has a sticky rollover flag that is set when the counter wraps. The flags are gathered into 16-bit words, and each word clears itself when read. Counter width, byte-count width, counter count and the octet counter indices are parameters. By default there are 64 counters of 40 bits, the receive octet counter is number 1 and the transmit octet counter is number 33.

Top module: `mac_stat_bank`

## Requirements
- R1: After synchronous reset, every live counter, every shadow value and every rollover flag is zero, and `hst_rvalid` is low.
- R2: A non-octet counter n adds exactly one in each clock cycle where `evt_pulse[n]` is high. Several counters may count in the same cycle.
- R3: The receive octet counter (index 1) adds `rx_oct_len`, and the transmit octet counter (index 33) adds `tx_oct_len`, in cycles where its own event bit is high. A nonzero length has no effect while that bit is low.
- R4: A command write (address 0x000, `hst_wdata` bit 0 = snapshot) copies all live counters into the shadow on one edge. Counter reads return the shadow, which stays unchanged while counting goes on until the next snapshot or clear.
- R5: An event in the same cycle as a snapshot is added to the live counter. It is missing from that snapshot and appears in the next one.
- R6: Counter n is read at 0x100 + 4n. Offset +0 returns bits 15:0, +1 returns bits 31:16, +2 returns bits above 31 zero-extended, and +3 returns zero.
- R7: Read data appears on `hst_rdata` with `hst_rvalid` high exactly one cycle after `hst_rd`. In every other cycle `hst_rvalid` is low and `hst_rdata` is zero.
- R8: A command write with `hst_wdata` bit 1 (clear) zeroes every live counter and every rollover flag. An event or wrap in that cycle is dropped. The shadow is zeroed too, unless the snapshot bit is set in the same write; in that case the shadow takes the values from before the clear.
- R9: When counter n wraps past its maximum, it keeps only the low bits of the sum and sets flag bit n%16 of the rollover word at address 0x004 + n/16.
- R10: Reading a rollover word returns it and then clears it. A flag that gets set in the same cycle as that read stays set for the next read.
- R11: A read of any address outside the command, rollover and counter regions, or of a counter index beyond the bank, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_CNT | One pulse bit per counter |
| rx_oct_len | input | LEN_W | Byte count for the receive octet counter |
| tx_oct_len | input | LEN_W | Byte count for the transmit octet counter |
| hst_wr | input | 1 | Host command write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 10 | Host register address |
| hst_wdata | input | 2 | Command bits: bit 0 snapshot, bit 1 clear |
| hst_rdata | output | 16 | Registered read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after `hst_rd` |

## Verification
On every cycle, the embedded assertions check these rules:
- The shadow moves only on a snapshot or a clear, and a snapshot takes the previous live value.
- A live counter never decreases unless it wraps or is cleared.
- A wrap always leaves its flag set on the next edge, even under a concurrent read.
- A clear empties the flags.
- The read valid strobe follows the read strobe.

Only the bench scenarios can show the rest. This covers the slice layout, the octet lengths, an event in the snapshot cycle landing in the following snapshot, a snapshot combined with a clear, and the exact cycle in which a long run of maximum-length frames wraps the receive octet counter while its flag word is read every cycle.

// File: rtl/mstat_pkg.sv
`timescale 1ns/1ps
package mstat_pkg;
    localparam int ADDR_W         = 10;
    localparam int DATA_W         = 16;
    localparam int CMD_W          = 2;
    localparam int CMD_SNAP_BIT   = 0;
    localparam int CMD_CLR_BIT    = 1;
    localparam int CNT_REGION_LSB = 8;
    localparam int IDX_W          = CNT_REGION_LSB - 2;
    localparam int SEL_W          = 2;

    localparam logic [ADDR_W-1:0]                CMD_ADDR   = '0;
    localparam logic [ADDR_W-CNT_REGION_LSB-1:0] CNT_TAG    = 1;
    localparam logic [ADDR_W-SEL_W-1:0]          ROLL_TAG   = 1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CNT  = 2'd1,
        TGT_ROLL = 2'd2
    } rd_tgt_e;

    typedef struct packed {
        logic             snap;
        logic             clr;
        rd_tgt_e          tgt;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } host_req_t;

    function automatic int words_for(input int n, input int w);
        return (n + w - 1) / w;
    endfunction
endpackage

// File: rtl/mstat_decode.sv
`timescale 1ns/1ps
module mstat_decode
    import mstat_pkg::*;
#(
    parameter int NUM_CNT    = 64,
    parameter int ROLL_WORDS = 4
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  wdata,
    output host_req_t         req_o
);
    always_comb begin
        req_o     = '0;
        req_o.tgt = TGT_NONE;
        if (wr && addr == CMD_ADDR) begin
            req_o.snap = wdata[CMD_SNAP_BIT];
            req_o.clr  = wdata[CMD_CLR_BIT];
        end
        if (rd) begin
            if (addr[ADDR_W-1:CNT_REGION_LSB] == CNT_TAG) begin
                req_o.idx = addr[CNT_REGION_LSB-1:SEL_W];
                req_o.sel = addr[SEL_W-1:0];
                if (int'(addr[CNT_REGION_LSB-1:SEL_W]) < NUM_CNT)
                    req_o.tgt = TGT_CNT;
            end else if (addr[ADDR_W-1:SEL_W] == ROLL_TAG
                         && int'(addr[SEL_W-1:0]) < ROLL_WORDS) begin
                req_o.sel = addr[SEL_W-1:0];
                req_o.tgt = TGT_ROLL;
            end
        end
    end
endmodule

// File: rtl/mstat_counter.sv
`timescale 1ns/1ps
module mstat_counter #(
    parameter int CNT_W = 40,
    parameter int INC_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             snap,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] shadow_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W:0]   sum;

    assign sum      = {1'b0, live_q} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    assign wrap_o   = sum[CNT_W] & ~clr;
    assign shadow_o = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (snap)
                shadow_q <= live_q;
            else if (clr)
                shadow_q <= '0;
            live_q <= clr ? '0 : sum[CNT_W-1:0];
        end
    end

    assert_snap_copy_R4: assert property (@(posedge clk) disable iff (rst)
        snap |=> shadow_q == $past(live_q));
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!snap && !clr) |=> $stable(shadow_q));
    assert_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wrap_o) |=> live_q >= $past(live_q));
    assert_clear_shadow_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !snap) |=> shadow_q == '0);
endmodule

// File: rtl/mstat_rollover.sv
`timescale 1ns/1ps
module mstat_rollover
    import mstat_pkg::*;
#(
    parameter int NUM_CNT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [NUM_CNT-1:0] wrap_i,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_word,
    output logic [DATA_W-1:0]  word_o
);
    localparam int WORDS = words_for(NUM_CNT, DATA_W);
    localparam int FLAT  = WORDS * DATA_W;

    logic [FLAT-1:0] flat_q;
    logic [FLAT-1:0] wrap_ext;
    logic [FLAT-1:0] rd_mask;

    generate
        if (FLAT > NUM_CNT) begin : g_pad
            assign wrap_ext = {{(FLAT-NUM_CNT){1'b0}}, wrap_i};
        end else begin : g_nopad
            assign wrap_ext = wrap_i;
        end
        for (genvar w = 0; w < WORDS; w++) begin : g_mask
            assign rd_mask[w*DATA_W +: DATA_W] =
                {DATA_W{rd_en && rd_word == SEL_W'(w)}};
        end
    endgenerate

    always_comb begin
        word_o = '0;
        for (int w = 0; w < WORDS; w++)
            if (rd_word == SEL_W'(w))
                word_o = flat_q[w*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            flat_q <= '0;
        else
            flat_q <= (flat_q & ~rd_mask) | wrap_ext;
    end

    assert_flag_kept_R10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (flat_q & $past(wrap_ext)) == $past(wrap_ext));
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> flat_q == '0);
endmodule

// File: rtl/mac_stat_bank.sv
`timescale 1ns/1ps
module mac_stat_bank
    import mstat_pkg::*;
#(
    parameter int NUM_CNT    = 64,
    parameter int CNT_W      = 40,
    parameter int LEN_W      = 14,
    parameter int RX_OCT_IDX = 1,
    parameter int TX_OCT_IDX = 33
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] evt_pulse,
    input  logic [LEN_W-1:0]   rx_oct_len,
    input  logic [LEN_W-1:0]   tx_oct_len,
    input  logic               hst_wr,
    input  logic               hst_rd,
    input  logic [ADDR_W-1:0]  hst_addr,
    input  logic [CMD_W-1:0]   hst_wdata,
    output logic [DATA_W-1:0]  hst_rdata,
    output logic               hst_rvalid
);
    localparam int HI_W       = CNT_W - 32;
    localparam int ROLL_WORDS = words_for(NUM_CNT, DATA_W);

    host_req_t          req;
    logic [CNT_W-1:0]   shadow [NUM_CNT];
    logic [NUM_CNT-1:0] wrap;
    logic [DATA_W-1:0]  roll_word;
    logic [CNT_W-1:0]   cnt_sel;
    logic [DATA_W-1:0]  cnt_slice;
    logic [DATA_W-1:0]  rd_next;
    logic [DATA_W-1:0]  rd_data_q;
    logic               rd_valid_q;

    mstat_decode #(.NUM_CNT(NUM_CNT), .ROLL_WORDS(ROLL_WORDS)) u_decode (
        .wr    (hst_wr),
        .rd    (hst_rd),
        .addr  (hst_addr),
        .wdata (hst_wdata),
        .req_o (req)
    );

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic [LEN_W-1:0] inc;
            if (i == RX_OCT_IDX) begin : g_rx_oct
                assign inc = evt_pulse[i] ? rx_oct_len : '0;
            end else if (i == TX_OCT_IDX) begin : g_tx_oct
                assign inc = evt_pulse[i] ? tx_oct_len : '0;
            end else begin : g_frame
                assign inc = {{(LEN_W-1){1'b0}}, evt_pulse[i]};
            end
            mstat_counter #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .clr      (req.clr),
                .snap     (req.snap),
                .inc      (inc),
                .shadow_o (shadow[i]),
                .wrap_o   (wrap[i])
            );
        end
    endgenerate

    mstat_rollover #(.NUM_CNT(NUM_CNT)) u_roll (
        .clk     (clk),
        .rst     (rst),
        .clr     (req.clr),
        .wrap_i  (wrap),
        .rd_en   (req.tgt == TGT_ROLL),
        .rd_word (req.sel),
        .word_o  (roll_word)
    );

    always_comb begin
        cnt_sel = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (req.idx == IDX_W'(i))
                cnt_sel = shadow[i];
        case (req.sel)
            2'd0:    cnt_slice = cnt_sel[15:0];
            2'd1:    cnt_slice = cnt_sel[31:16];
            2'd2:    cnt_slice = {{(DATA_W-HI_W){1'b0}}, cnt_sel[CNT_W-1:32]};
            default: cnt_slice = '0;
        endcase
        case (req.tgt)
            TGT_CNT:  rd_next = cnt_slice;
            TGT_ROLL: rd_next = roll_word;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= hst_rd;
            rd_data_q  <= hst_rd ? rd_next : '0;
        end
    end

    assign hst_rdata  = rd_data_q;
    assign hst_rvalid = rd_valid_q;

    assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        hst_rd |=> hst_rvalid);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !hst_rd |=> (!hst_rvalid && hst_rdata == '0));
endmodule

// File: tb/mac_stat_bank_tb.sv
`timescale 1ns/1ps
module mac_stat_bank_tb_top;
    localparam int NC  = 64;
    localparam int CW  = 36;
    localparam int LW  = 24;
    localparam int RXI = 1;
    localparam int TXI = 33;
    localparam longint unsigned MASK   = (64'd1 << CW) - 1;
    localparam logic [LW-1:0]   MAXLEN = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] evt_pulse = '0;
    logic [LW-1:0] rx_oct_len = '0;
    logic [LW-1:0] tx_oct_len = '0;
    logic          hst_wr = 1'b0;
    logic          hst_rd = 1'b0;
    logic [9:0]    hst_addr = '0;
    logic [1:0]    hst_wdata = '0;
    logic [15:0]   hst_rdata;
    logic          hst_rvalid;

    always #2.5 clk = ~clk;

    mac_stat_bank #(.NUM_CNT(NC), .CNT_W(CW), .LEN_W(LW),
                    .RX_OCT_IDX(RXI), .TX_OCT_IDX(TXI)) dut_i (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
        .rx_oct_len(rx_oct_len), .tx_oct_len(tx_oct_len),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid)
    );

    // behavioural reference
    longint unsigned m_live   [NC];
    longint unsigned m_shadow [NC];
    longint unsigned m_flags;
    longint unsigned rdmask, newroll, inc, sum;
    logic        exp_valid = 1'b0;
    logic [15:0] exp_data  = '0;
    logic        snap_c, clr_c;

    int    vectors = 0;
    int    errors  = 0;
    string tag     = "R1";
    bit    chk_en  = 1'b0;
    bit    done    = 1'b0;

    function automatic logic [15:0] model_read(input logic [9:0] a);
        int unsigned ua = a;
        if (ua >= 256 && ua < 256 + 4*NC) begin
            int unsigned n = (ua - 256) / 4;
            case (ua % 4)
                0: return 16'(m_shadow[n]);
                1: return 16'(m_shadow[n] >> 16);
                2: return 16'(m_shadow[n] >> 32);
                default: return 16'h0;
            endcase
        end
        if (ua >= 4 && ua <= 7)
            return 16'(m_flags >> (16 * (ua - 4)));
        return 16'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                m_live[i] = 0;
                m_shadow[i] = 0;
            end
            m_flags = 0; exp_valid = 1'b0; exp_data = '0;
        end else begin
            exp_valid = hst_rd;
            exp_data  = hst_rd ? model_read(hst_addr) : 16'h0;
            snap_c = hst_wr && hst_addr == 10'd0 && hst_wdata[0];
            clr_c  = hst_wr && hst_addr == 10'd0 && hst_wdata[1];
            rdmask = 0;
            if (hst_rd && hst_addr >= 10'd4 && hst_addr <= 10'd7)
                rdmask = 64'hFFFF << (16 * (int'(hst_addr) - 4));
            newroll = 0;
            for (int i = 0; i < NC; i++) begin
                if (i == RXI)      inc = evt_pulse[i] ? rx_oct_len : 0;
                else if (i == TXI) inc = evt_pulse[i] ? tx_oct_len : 0;
                else               inc = evt_pulse[i];
                sum = m_live[i] + inc;
                if (snap_c)     m_shadow[i] = m_live[i];
                else if (clr_c) m_shadow[i] = 0;
                if (clr_c) m_live[i] = 0;
                else begin
                    if ((sum >> CW) != 0) newroll = newroll | (64'd1 << i);
                    m_live[i] = sum & MASK;
                end
            end
            m_flags = clr_c ? 0 : ((m_flags & ~rdmask) | newroll);
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            vectors++;
            if (hst_rvalid !== exp_valid || hst_rdata !== exp_data) begin
                errors++;
                $display("FAIL %s: rvalid/rdata actual %0b/%h expected %0b/%h",
                         tag, hst_rvalid, hst_rdata, exp_valid, exp_data);
            end
        end
    end

    task automatic idle_in();
        evt_pulse = '0; rx_oct_len = '0; tx_oct_len = '0;
        hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
    endtask
    task automatic cyc();
        @(negedge clk); idle_in();
    endtask
    task automatic rd(input int a);
        cyc(); hst_rd = 1'b1; hst_addr = 10'(a);
    endtask
    task automatic cmd(input logic s, input logic c);
        cyc(); hst_wr = 1'b1; hst_addr = '0; hst_wdata = {c, s};
    endtask
    task automatic pulse(input int i);
        cyc(); evt_pulse[i] = 1'b1;
    endtask
    task automatic rd_cnt(input int n);
        for (int k = 0; k < 4; k++) rd(256 + 4*n + k);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (hst_rvalid !== 1'b0 || hst_rdata !== 16'h0) begin  // R1
            errors++;
            $display("FAIL R1: reset rvalid/rdata actual %0b/%h expected 0/0000",
                     hst_rvalid, hst_rdata);
        end
        rst = 1'b0; chk_en = 1'b1;

        tag = "R1";  // all zero after reset
        for (int w = 4; w < 8; w++) rd(w);
        cmd(1'b1, 1'b0);
        rd_cnt(0); rd_cnt(63);

        tag = "R2";  // one per pulse, several counters together
        for (int k = 0; k < 5; k++) pulse(4);
        for (int k = 0; k < 6; k++) begin
            cyc(); evt_pulse[10] = k[0]; evt_pulse[63] = 1'b1; evt_pulse[4] = 1'b1;
        end
        cmd(1'b1, 1'b0);
        rd_cnt(4); rd_cnt(10); rd_cnt(63);

        tag = "R3";  // octet counters add lengths; length alone ignored
        cyc(); evt_pulse[RXI] = 1'b1; rx_oct_len = 24'd1500;
        cyc(); evt_pulse[TXI] = 1'b1; tx_oct_len = 24'd64;
        cyc(); evt_pulse[RXI] = 1'b1; evt_pulse[TXI] = 1'b1;
               rx_oct_len = 24'd9600; tx_oct_len = 24'd9600;
        cyc(); rx_oct_len = 24'd777; tx_oct_len = 24'd555;
        cmd(1'b1, 1'b0);
        rd_cnt(RXI); rd_cnt(TXI);

        tag = "R4";  // shadow stable while counting continues
        for (int k = 0; k < 10; k++) pulse(4);
        rd_cnt(4);
        cmd(1'b1, 1'b0);
        rd_cnt(4);

        tag = "R5";  // event in the snapshot cycle
        cmd(1'b1, 1'b0); evt_pulse[5] = 1'b1;
        rd_cnt(5);
        cmd(1'b1, 1'b0);
        rd_cnt(5);

        tag = "R8";  // clear, with event and with snapshot
        cmd(1'b0, 1'b1); evt_pulse[4] = 1'b1;
        rd_cnt(4);
        cmd(1'b1, 1'b0);
        rd_cnt(4);
        for (int k = 0; k < 3; k++) pulse(4);
        cmd(1'b1, 1'b1);
        rd_cnt(4);
        cmd(1'b1, 1'b0);
        rd_cnt(4);
        rd(4); rd(6);

        tag = "R6";  // upper slice of a large octet count
        for (int k = 0; k < 2100; k++) begin
            cyc(); evt_pulse[RXI] = 1'b1; rx_oct_len = MAXLEN;
            evt_pulse[TXI] = 1'b1; tx_oct_len = MAXLEN;
        end
        cmd(1'b1, 1'b0);
        rd_cnt(RXI); rd_cnt(TXI);

        tag = "R10";  // wrap while reading its flag word each cycle
        for (int k = 0; k < 2000; k++) begin
            cyc(); evt_pulse[RXI] = 1'b1; rx_oct_len = MAXLEN;
            evt_pulse[TXI] = 1'b1; tx_oct_len = MAXLEN;
            hst_rd = 1'b1; hst_addr = 10'd4;
        end
        tag = "R9";
        rd(6); rd(6); rd(4);
        cmd(1'b1, 1'b0);
        rd_cnt(RXI); rd_cnt(TXI);

        tag = "R11";
        rd(0); rd(3); rd(8); rd(255); rd(512); rd(1023);

        tag = "R7";
        rd(256 + 4*4); cyc(); rd(256 + 4*10); rd(256 + 4*63 + 1);
        cyc(); cyc(); cyc();

        done = 1'b1; chk_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule